// File: doc/BRIEF.md
# Keypad Register Entry Controller

This block turns strobes from a thirteen-key numeric pad into a signed ten-digit decimal word, ready to be loaded into whichever register the surrounding logic has selected. Every digit is held in a four-bit weighted code. The three low bits carry the binary weights 1, 2 and 4, and the top bit carries weight 5. The keys are a start key, ten digit keys (0 to 9), a plus key and a minus key.

An entry has to open with the start key. Digit keys pressed outside an entry have no effect. Each accepted digit enters at the least significant position and pushes the older digits toward the top. The block does not count digits, so the oldest ones simply drop out once more than ten have been typed. A digit code that is not a decimal value is entered by pressing two digit keys in the same cycle; the stored pattern is the bitwise OR of the two codes. Pressing plus or minus closes the entry. The sign is stored, a load strobe pulses for one clock, and the block goes back to idle to wait for the next start key. The assembled word stays on the outputs until the next start key clears it. The key inputs are already-debounced single-cycle strobes, all sampled on the rising clock edge.

Top module: `kp_entry_ctrl`

## Requirements
- R1: After reset the digit field is all zero, the sign is 0, the load strobe is 0 and busy is 0.
- R2: While busy is 0, digit keys leave the digit field and the sign unchanged.
- R3: The start key sets busy and clears the digit field and the sign to zero at the next clock edge.
- R4: A single digit key d is stored as the four-bit code {d>=5, d mod 5} (bit 3 has weight 5 and bits 2:0 weights 4, 2, 1). For example 0 gives 0000, 4 gives 0100, 5 gives 1000 and 9 gives 1100.
- R5: Each accepted digit shifts the field left by four bits and enters at bits 3:0. Digits that move past bits 39:36 are lost, and no count of typed digits is checked.
- R6: When exactly two digit keys strobe in the same cycle during an entry, the value shifted in is the bitwise OR of their two codes.
- R7: When three or more digit keys strobe in the same cycle, the digit field is left unchanged.
- R8: During an entry, plus or minus pulses the load strobe high for exactly one clock and clears busy at the same edge. The sign output becomes 0 for plus and 1 for minus.
- R9: After the load strobe, the digit field and the sign hold their values until the next start key.
- R10: A start key during an entry, or together with any other key, restarts the entry: the field and the sign are cleared, busy stays 1 and no load strobe occurs.
- R11: If a sign key strobes in the same cycle as digit keys during an entry, the digits are discarded and the sign ends the entry.
- R12: If plus and minus strobe together during an entry, the entry ends with the sign set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_a | input | 1 | Start-key strobe |
| key_digit | input | 10 | Digit-key strobes; bit k is digit k |
| key_plus | input | 1 | Plus sign-key strobe |
| key_minus | input | 1 | Minus sign-key strobe |
| word_digits | output | 40 | Assembled digit field; bits 3:0 hold the newest digit |
| word_neg | output | 1 | Sign of the entered word; 1 means negative |
| load_strobe | output | 1 | One-clock pulse when an entry is closed |
| busy | output | 1 | High while an entry is open |

## Verification
The bench types digits before any start key and then checks that nothing was captured. A design that listens in idle would show those digits in the field. It types twelve digits into one entry, so a design that saturates at ten, or shifts in the wrong direction, keeps the wrong ten digits. It presses two-key chords whose OR gives a non-decimal code, and a three-key press that must be dropped. A design that adds the codes, or takes the lowest key, stores a different pattern. It also applies a sign together with digits, plus together with minus, and a start key in the middle of an entry. A design with the wrong priority would shift in the extra digit, choose plus, or fire the load strobe.

// File: rtl/kp_pkg.sv
package kp_pkg;

  localparam int unsigned DIGIT_W  = 4;
  localparam int unsigned NUM_KEYS = 10;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ENTRY = 1'b1
  } kp_state_e;

  // Weighted 1-2-4-5 code: bit 3 is the five, bits 2:0 are the remainder.
  function automatic logic [DIGIT_W-1:0] bq_code(input int unsigned d);
    logic [DIGIT_W-1:0] r;
    if (d >= 5) r = {1'b1, 3'(d - 5)};
    else        r = {1'b0, 3'(d)};
    return r;
  endfunction

  // A key press is a usable digit when one or two keys are pressed.
  function automatic logic press_usable(input int unsigned n);
    return (n == 1) || (n == 2);
  endfunction

endpackage

// File: rtl/kp_key_encoder.sv
module kp_key_encoder
  import kp_pkg::*;
#(
  parameter int unsigned KEYS = NUM_KEYS
) (
  input  logic [KEYS-1:0]    keys,
  output logic [DIGIT_W-1:0] code,
  output logic               valid
);

  logic [DIGIT_W-1:0] code_tab [KEYS];
  logic [DIGIT_W-1:0] or_acc;
  int unsigned        n_pressed;

  for (genvar k = 0; k < KEYS; k++) begin : g_tab
    assign code_tab[k] = bq_code(k);
  end

  always_comb begin
    or_acc = '0;
    for (int k = 0; k < KEYS; k++) begin
      if (keys[k]) or_acc = or_acc | code_tab[k];
    end
  end

  assign n_pressed = $countones(keys);
  assign valid     = press_usable(n_pressed);
  assign code      = valid ? or_acc : '0;

endmodule

// File: rtl/kp_entry_fsm.sv
module kp_entry_fsm
  import kp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_key,
  input  logic plus_key,
  input  logic minus_key,
  input  logic digit_valid,
  output logic busy,
  output logic load_q,
  output logic neg_q,
  output logic clear_en,
  output logic shift_en
);

  kp_state_e state_q, state_d;
  logic      sign_any;
  logic      close_ev;

  assign sign_any = plus_key | minus_key;
  assign clear_en = start_key;
  assign close_ev = (state_q == ST_ENTRY) && sign_any && !start_key;
  assign shift_en = (state_q == ST_ENTRY) && !start_key && !sign_any && digit_valid;
  assign busy     = (state_q == ST_ENTRY);

  always_comb begin
    state_d = state_q;
    if (start_key)     state_d = ST_ENTRY;
    else if (close_ev) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      load_q  <= 1'b0;
      neg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      load_q  <= close_ev;
      if (start_key)     neg_q <= 1'b0;
      else if (close_ev) neg_q <= minus_key;
    end
  end

  // R8
  load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |=> !load_q);

  // R3
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_key |=> (busy && !neg_q && !load_q));

  // R12
  minus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && minus_key && !start_key) |=> (neg_q && load_q));

endmodule

// File: rtl/kp_word_shifter.sv
module kp_word_shifter
  import kp_pkg::*;
#(
  parameter int unsigned DIGITS = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_en,
  input  logic                       shift_en,
  input  logic [DIGIT_W-1:0]         code_in,
  output logic [DIGITS*DIGIT_W-1:0]  word_q
);

  localparam int unsigned WORD_W = DIGITS * DIGIT_W;
  localparam int unsigned KEEP_W = WORD_W - DIGIT_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (clear_en) word_q <= '0;
    else if (shift_en) word_q <= {word_q[KEEP_W-1:0], code_in};
  end

  // R5
  shift_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear_en) |=>
      (word_q[DIGIT_W-1:0] == $past(code_in) &&
       word_q[WORD_W-1:DIGIT_W] == $past(word_q[KEEP_W-1:0])));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_en && !shift_en) |=> $stable(word_q));

endmodule

// File: rtl/kp_entry_ctrl.sv
module kp_entry_ctrl
  import kp_pkg::*;
#(
  parameter int unsigned DIGITS = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      key_a,
  input  logic [NUM_KEYS-1:0]       key_digit,
  input  logic                      key_plus,
  input  logic                      key_minus,
  output logic [DIGITS*DIGIT_W-1:0] word_digits,
  output logic                      word_neg,
  output logic                      load_strobe,
  output logic                      busy
);

  logic [DIGIT_W-1:0] enc_code;
  logic               enc_valid;
  logic               clear_en;
  logic               shift_en;

  kp_key_encoder #(.KEYS(NUM_KEYS)) u_enc (
    .keys  (key_digit),
    .code  (enc_code),
    .valid (enc_valid)
  );

  kp_entry_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_key   (key_a),
    .plus_key    (key_plus),
    .minus_key   (key_minus),
    .digit_valid (enc_valid),
    .busy        (busy),
    .load_q      (load_strobe),
    .neg_q       (word_neg),
    .clear_en    (clear_en),
    .shift_en    (shift_en)
  );

  kp_word_shifter #(.DIGITS(DIGITS)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_en (clear_en),
    .shift_en (shift_en),
    .code_in  (enc_code),
    .word_q   (word_digits)
  );

  // R8
  load_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> !busy);

  // R2
  idle_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !key_a) |=> ($stable(word_digits) && $stable(word_neg)));

endmodule

// File: tb/kp_entry_ctrl_test.sv
`timescale 1ns/1ps
module kp_entry_ctrl_test;

  typedef struct {
    logic [39:0] digits;
    logic        neg;
    logic        load;
    logic        busy;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_a = 1'b0;
  logic [9:0]  key_digit = '0;
  logic        key_plus = 1'b0;
  logic        key_minus = 1'b0;
  logic [39:0] word_digits;
  logic        word_neg;
  logic        load_strobe;
  logic        busy;

  int vectors = 0;
  int errors  = 0;
  exp_t q[$];

  // model state
  logic [39:0] m_w = '0;
  logic        m_n = 1'b0;
  logic        m_b = 1'b0;

  always #2 clk = ~clk;

  kp_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .key_a(key_a), .key_digit(key_digit),
    .key_plus(key_plus), .key_minus(key_minus), .word_digits(word_digits),
    .word_neg(word_neg), .load_strobe(load_strobe), .busy(busy)
  );

  function automatic logic [3:0] wcode(input int d);
    logic [3:0] r;
    r[3]   = (d / 5) != 0;
    r[2:0] = 3'(d % 5);
    return r;
  endfunction

  task automatic compare(input exp_t e);
    vectors++;
    if (word_digits !== e.digits || word_neg !== e.neg ||
        load_strobe !== e.load || busy !== e.busy) begin
      errors++;
      $display("FAIL %s: got digits=%h neg=%b load=%b busy=%b, expected digits=%h neg=%b load=%b busy=%b",
               e.req, word_digits, word_neg, load_strobe, busy,
               e.digits, e.neg, e.load, e.busy);
    end
  endtask

  // Monitor: pops one expectation per clock, just after the edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) compare(q.pop_front());
  end

  // Driver: apply one cycle of keys and push the expected result.
  task automatic step(input logic a, input logic [9:0] dig,
                      input logic p, input logic m, input string req);
    exp_t e;
    logic [3:0] orv;
    int cnt;
    @(negedge clk);
    key_a = a; key_digit = dig; key_plus = p; key_minus = m;
    orv = '0; cnt = 0;
    for (int k = 0; k < 10; k++) if (dig[k]) begin orv |= wcode(k); cnt++; end
    e.load = 1'b0;
    if (a) begin
      m_w = '0; m_n = 1'b0; m_b = 1'b1;
    end else if (m_b && (p || m)) begin
      m_n = m; m_b = 1'b0; e.load = 1'b1;
    end else if (m_b && (cnt == 1 || cnt == 2)) begin
      m_w = {m_w[35:0], orv};
    end
    e.digits = m_w; e.neg = m_n; e.busy = m_b; e.req = req;
    q.push_back(e);
  endtask

  task automatic digit(input int d, input string req);
    logic [9:0] v;
    v = '0; v[d] = 1'b1;
    step(1'b0, v, 1'b0, 1'b0, req);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    r.digits = '0; r.neg = 0; r.load = 0; r.busy = 0; r.req = "R1 reset";
    compare(r);
    rst_n = 1'b1;
    step(0, '0, 0, 0, "R1 idle after reset");
    // R2: digits and sign before start key
    digit(5, "R2 digit in idle");
    digit(3, "R2 digit in idle");
    step(0, '0, 1, 0, "R2 sign in idle");
    // R3 start
    step(1, '0, 0, 0, "R3 start");
    // R4/R5: every digit value
    for (int d = 1; d < 10; d++) digit(d, "R4 R5 code and shift");
    digit(0, "R4 R5 code zero");
    step(0, '0, 1, 0, "R8 plus closes");
    step(0, '0, 0, 0, "R8 strobe one cycle");
    // R9: held after load, digits ignored
    digit(7, "R9 hold after load");
    step(0, '0, 0, 1, "R9 sign ignored after load");
    // R5: twelve digits, oldest dropped
    step(1, '0, 0, 0, "R3 second start");
    for (int i = 0; i < 12; i++) digit((i * 7 + 2) % 10, "R5 overflow drop");
    step(0, '0, 0, 1, "R8 minus closes");
    step(0, '0, 0, 0, "R9 held negative");
    // R6/R7 chords
    step(1, '0, 0, 0, "R3 start three");
    step(0, 10'b00_0001_0010, 0, 0, "R6 chord 1|4");
    step(0, 10'b10_1000_0000, 0, 0, "R6 chord 7|9");
    step(0, 10'b00_0000_0110, 0, 0, "R6 chord 1|2");
    step(0, 10'b00_0010_1001, 0, 0, "R7 three keys");
    step(0, 10'b11_1111_1111, 0, 0, "R7 all keys");
    // R11 sign with digits
    step(0, 10'b00_0000_1000, 1, 0, "R11 sign with digit");
    step(0, '0, 0, 0, "R11 after close");
    // R12 plus and minus together
    step(1, '0, 0, 0, "R3 start four");
    digit(8, "R4 digit eight");
    step(0, '0, 1, 1, "R12 plus and minus");
    step(0, '0, 0, 0, "R12 after close");
    // R10 restart during entry
    step(1, '0, 0, 0, "R3 start five");
    digit(6, "R5 digit");
    digit(2, "R5 digit");
    step(1, 10'b00_0000_0010, 0, 0, "R10 restart with digit");
    digit(4, "R10 after restart");
    step(1, '0, 0, 1, "R10 start beats sign");
    step(0, '0, 0, 0, "R10 no load");
    step(0, '0, 1, 0, "R8 final close");
    step(0, '0, 0, 0, "R8 idle");
    @(negedge clk);
    key_a = 0; key_digit = '0; key_plus = 0; key_minus = 0;
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule